// File: doc/BRIEF.md
# Two-Tone NRZI Audio Tone Generator

This block turns a serial bit stream into a two-tone audio waveform for a 4-bit resistor-ladder DAC. A baud timer runs on a 1 MHz timebase enable. On each baud tick it asks the data source for one bit. An incoming 0 flips the current line symbol and a 1 keeps it (NRZI). The symbol picks one of two tone-step rates, and the chosen rate walks a 32-entry sine table on a 4 MHz enable.

On every baud tick the tone-step counter restarts from zero and starts using the new rate. The sine index is never reset, so the phase of the waveform carries across each tone change. A mode input gives three test modes: a steady mark tone, a steady space tone, and a tone that alternates on every baud tick whatever the data.

Top module: `afsk_tone_gen`

## Requirements
- R1: After reset `dac_out` is 8, `symbol` is 0 and `bit_req` is 0.
- R2: In data mode (`mode`=2'b00) and alternating mode (`mode`=2'b11), a baud tick occurs on every 833rd `baud_ce` pulse. That is a reload of 1,000,000/1200−1 = 832, and the count starts from reset or from the last steady mode. `bit_req` is only ever high together with `baud_ce`.
- R3: In data mode, `bit_req` is a single-cycle pulse on each baud tick, and `tx_bit` is sampled in that same cycle. A sampled 0 inverts `symbol` from the next cycle on, and a sampled 1 leaves it unchanged. Between ticks `symbol` does not change.
- R4: In alternating mode `symbol` inverts on every baud tick, and `bit_req` stays 0.
- R5: While the active symbol is 0 (mark), a tone step happens when the tone counter has reached 103 (4,000,000/(32·1200)−1) and `tone_ce` is high. While it is 1 (space) the limit is 55 (4,000,000/(32·2200)−1). A step returns the counter to 0, and the counter is compared with "reached or above".
- R6: A baud tick returns the tone counter to zero, and from there it counts toward the reload of the new symbol. The sine index keeps its value across the tick.
- R7: On a tone step, `dac_out` takes the table entry at the current 5-bit index, and the index then advances by one modulo 32. `dac_out` changes at no other time.
- R8: Table entry i is floor(7·sin(2πi/32) + 8). Its values run from 1 to 15, with 8 at i = 0 and i = 16.
- R9: In steady mark mode (`mode`=2'b01) only the mark rate is used, and in steady space mode (`mode`=2'b10) only the space rate. In both, no baud tick occurs, `bit_req` stays 0 and `symbol` holds.
- R10: While `tone_ce` is low the tone counter does not advance and `dac_out` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tone_ce | input | 1 | 4 MHz tone-step enable |
| baud_ce | input | 1 | 1 MHz baud timebase enable |
| mode | input | 2 | 00 data, 01 steady mark, 10 steady space, 11 alternating |
| tx_bit | input | 1 | Data bit from the source, sampled when `bit_req` is high |
| bit_req | output | 1 | Request for the next data bit, one cycle wide |
| symbol | output | 1 | Current NRZI line symbol (1 = space tone) |
| dac_out | output | 4 | Sample for the resistor-ladder DAC |

## Verification
A baud counter that is off by even one `baud_ce` pulse moves `bit_req` to the wrong cycle, and this shows on the very first tick, about 833 pulses after reset. A wrong symbol or a wrong rate selection shows in `dac_out` within one tone period, because the sample spacing becomes 56 or 104 tone enables instead of the other value. A tone counter that is not cleared on a tick, or a sine index that is reset, shifts the next sample edge or the next sample value just after that tick. The bench follows all of this with a cycle-exact behavioural model and compares every output on every clock.

// File: rtl/afsk_tone_pkg.sv
package afsk_tone_pkg;

  localparam int SINE_DEPTH = 32;
  localparam int IDX_W      = 5;
  localparam int DAC_W      = 4;

  typedef enum logic [1:0] {
    MODE_DATA  = 2'b00,
    MODE_MARK  = 2'b01,
    MODE_SPACE = 2'b10,
    MODE_ALT   = 2'b11
  } tx_mode_e;

  // timer reload for an event rate derived from a source enable rate
  function automatic int period_reload(input int src_hz, input int rate_hz);
    return src_hz / rate_hz - 1;
  endfunction

  // tone-step reload: one table entry per step, SINE_DEPTH steps per tone cycle
  function automatic int tone_reload(input int src_hz, input int tone_hz);
    return src_hz / (SINE_DEPTH * tone_hz) - 1;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // floor(7*sin(2*pi*idx/32) + 8), built from one quarter wave
  function automatic logic [DAC_W-1:0] sine_level(input logic [IDX_W-1:0] idx);
    logic [4:0] pos;
    logic [2:0] mag_floor;
    logic [2:0] mag_ceil;
    pos = {1'b0, idx[3:0]};
    if (pos > 5'd8) pos = 5'd16 - pos;
    case (pos)
      5'd0:    begin mag_floor = 3'd0; mag_ceil = 3'd0; end
      5'd1:    begin mag_floor = 3'd1; mag_ceil = 3'd2; end
      5'd2:    begin mag_floor = 3'd2; mag_ceil = 3'd3; end
      5'd3:    begin mag_floor = 3'd3; mag_ceil = 3'd4; end
      5'd4:    begin mag_floor = 3'd4; mag_ceil = 3'd5; end
      5'd5:    begin mag_floor = 3'd5; mag_ceil = 3'd6; end
      5'd6:    begin mag_floor = 3'd6; mag_ceil = 3'd7; end
      5'd7:    begin mag_floor = 3'd6; mag_ceil = 3'd7; end
      default: begin mag_floor = 3'd7; mag_ceil = 3'd7; end
    endcase
    if (!idx[4]) return 4'd8 + {1'b0, mag_floor};
    else         return 4'd8 - {1'b0, mag_ceil};
  endfunction

endpackage

// File: rtl/afsk_baud_timer.sv
module afsk_baud_timer #(
  parameter int RELOAD = 832
) (
  input  logic clk,
  input  logic rst_n,
  input  logic baud_ce,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (RELOAD < 1) ? 1 : $clog2(RELOAD + 1);

  logic [CNT_W-1:0] cnt;
  logic             at_end;

  assign at_end = (cnt == CNT_W'(RELOAD));
  assign tick   = run & baud_ce & at_end;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (baud_ce) cnt <= at_end ? '0 : cnt + 1'b1;
  end

  // R2: counter never passes the reload, restarts after a tick
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(RELOAD));
  p_tick_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == '0));

endmodule

// File: rtl/afsk_nrzi_coder.sv
module afsk_nrzi_coder
  import afsk_tone_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  tx_mode_e mode,
  input  logic     tick,
  input  logic     tx_bit,
  output logic     bit_req,
  output logic     symbol
);
  logic flip;

  assign bit_req = tick && (mode == MODE_DATA);
  assign flip    = tick && ((mode == MODE_ALT) || ((mode == MODE_DATA) && !tx_bit));

  always_ff @(posedge clk) begin
    if (!rst_n)    symbol <= 1'b0;
    else if (flip) symbol <= ~symbol;
  end

  // R3: symbol only moves on a tick, a 1 bit keeps it
  p_sym_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(symbol));
  p_one_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_req && tx_bit) |=> $stable(symbol));
  // R4: alternating mode flips on every tick
  p_alt_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == MODE_ALT) |=> (symbol != $past(symbol)));

endmodule

// File: rtl/afsk_tone_synth.sv
module afsk_tone_synth
  import afsk_tone_pkg::*;
#(
  parameter int MARK_RL  = 103,
  parameter int SPACE_RL = 55
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tone_ce,
  input  logic             restart,
  input  logic             space_sel,
  output logic [DAC_W-1:0] dac
);
  localparam int TOP_RL = max_of(MARK_RL, SPACE_RL);
  localparam int CNT_W  = (TOP_RL < 1) ? 1 : $clog2(TOP_RL + 1);
  localparam logic [DAC_W-1:0] DAC_MID = DAC_W'(2 ** (DAC_W - 1));

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] reload;
  logic [IDX_W-1:0] idx;
  logic             step;

  assign reload = space_sel ? CNT_W'(SPACE_RL) : CNT_W'(MARK_RL);
  assign step   = tone_ce && (cnt >= reload);

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (restart || step)  cnt <= '0;
    else if (tone_ce)          cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    idx <= '0;
    else if (step) idx <= idx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    dac <= DAC_MID;
    else if (step) dac <= sine_level(idx);
  end

  // R5: counter stays within the larger reload
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(TOP_RL));
  // R6: baud tick re-arms the counter but leaves the index alone
  p_restart_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));
  p_idx_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !step) |=> $stable(idx));
  // R7: output only changes on a step
  p_dac_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(dac));
  // R10: no enable, no counting
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tone_ce |=> $stable(cnt) || (cnt == '0));

endmodule

// File: rtl/afsk_tone_gen.sv
module afsk_tone_gen
  import afsk_tone_pkg::*;
#(
  parameter int TONE_CLK_HZ = 4_000_000,
  parameter int BAUD_CLK_HZ = 1_000_000,
  parameter int BAUD_HZ     = 1200,
  parameter int MARK_HZ     = 1200,
  parameter int SPACE_HZ    = 2200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tone_ce,
  input  logic       baud_ce,
  input  logic [1:0] mode,
  input  logic       tx_bit,
  output logic       bit_req,
  output logic       symbol,
  output logic [3:0] dac_out
);
  localparam int BAUD_RL  = period_reload(BAUD_CLK_HZ, BAUD_HZ);
  localparam int MARK_RL  = tone_reload(TONE_CLK_HZ, MARK_HZ);
  localparam int SPACE_RL = tone_reload(TONE_CLK_HZ, SPACE_HZ);

  tx_mode_e mode_e;
  logic     steady;
  logic     baud_tick;
  logic     space_sel;

  assign mode_e    = tx_mode_e'(mode);
  assign steady    = (mode_e == MODE_MARK) || (mode_e == MODE_SPACE);
  assign space_sel = (mode_e == MODE_SPACE) || ((mode_e != MODE_MARK) && symbol);

  afsk_baud_timer #(.RELOAD(BAUD_RL)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .baud_ce (baud_ce),
    .run     (!steady),
    .tick    (baud_tick)
  );

  afsk_nrzi_coder u_nrzi (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode_e),
    .tick    (baud_tick),
    .tx_bit  (tx_bit),
    .bit_req (bit_req),
    .symbol  (symbol)
  );

  afsk_tone_synth #(.MARK_RL(MARK_RL), .SPACE_RL(SPACE_RL)) u_synth (
    .clk       (clk),
    .rst_n     (rst_n),
    .tone_ce   (tone_ce),
    .restart   (baud_tick),
    .space_sel (space_sel),
    .dac       (dac_out)
  );

  // R2: a bit request can only come with a baud timebase pulse
  p_req_on_baud_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_req |-> baud_ce);
  // R9: steady modes freeze the symbol
  p_steady_sym_r9: assert property (@(posedge clk) disable iff (!rst_n)
    steady |=> $stable(symbol));

endmodule

// File: tb/afsk_tone_gen_bench.sv
module afsk_tone_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190_000;

  localparam int BAUD_RL  = 1_000_000 / 1200 - 1;
  localparam int MARK_RL  = 4_000_000 / (32 * 1200) - 1;
  localparam int SPACE_RL = 4_000_000 / (32 * 2200) - 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tone_ce = 1'b0;
  logic       baud_ce = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       tx_bit = 1'b0;
  logic       bit_req;
  logic       symbol;
  logic [3:0] dac_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural reference state
  int m_bcnt, m_tcnt, m_idx, m_dac, m_sym;
  int req_seen, dac_min, dac_max, cyc;

  always #(CLK_PERIOD / 2) clk = ~clk;

  afsk_tone_gen u_afsk_tone_gen (
    .clk     (clk),
    .rst_n   (rst_n),
    .tone_ce (tone_ce),
    .baud_ce (baud_ce),
    .mode    (mode),
    .tx_bit  (tx_bit),
    .bit_req (bit_req),
    .symbol  (symbol),
    .dac_out (dac_out)
  );

  function automatic int table_val(input int i);
    return int'($floor(7.0 * $sin(2.0 * 3.14159265358979 * i / 32.0) + 8.0));
  endfunction

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // bit_mode: 0 random, 1 all ones; ce_mode: 0 always, 1 random, 2 off
  task automatic run_phase(input int n, input int md, input int ce_mode,
                           input int bit_mode, input string tag);
    for (int k = 0; k < n; k++) begin
      bit tce, bce, txb, tick, req_exp, step;
      int rl, rate;
      @(negedge clk);
      check(int'(dac_out), m_dac, {"R5 R6 R7 R8 ", tag});
      check(int'(symbol), m_sym, {"R3 R4 ", tag});
      if (m_dac < dac_min) dac_min = m_dac;
      if (m_dac > dac_max) dac_max = m_dac;
      tce = (ce_mode == 0) ? 1'b1 : (ce_mode == 1) ? 1'($urandom_range(0, 1)) : 1'b0;
      bce = ((cyc % 4) == 0);
      txb = (bit_mode == 1) ? 1'b1 : 1'($urandom_range(0, 1));
      tone_ce = tce; baud_ce = bce; mode = 2'(md); tx_bit = txb;
      #1;
      tick    = (md == 0 || md == 3) && bce && (m_bcnt == BAUD_RL);
      req_exp = tick && (md == 0);
      check(int'(bit_req), int'(req_exp), {"R3 ", tag});
      if (bit_req) req_seen++;
      // next model state
      if (md == 1 || md == 2) m_bcnt = 0;
      else if (bce) m_bcnt = (m_bcnt == BAUD_RL) ? 0 : m_bcnt + 1;
      rate = (md == 1) ? 0 : (md == 2) ? 1 : m_sym;
      rl   = rate ? SPACE_RL : MARK_RL;
      step = tce && (m_tcnt >= rl);
      if (step) begin
        m_dac = table_val(m_idx);
        m_idx = (m_idx + 1) % 32;
      end
      if (tick || step) m_tcnt = 0;
      else if (tce) m_tcnt = m_tcnt + 1;
      if (tick && (md == 3 || (md == 0 && !txb))) m_sym = 1 - m_sym;
      cyc++;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int req_a, dac_hold;
    m_bcnt = 0; m_tcnt = 0; m_idx = 0; m_dac = 8; m_sym = 0;
    req_seen = 0; dac_min = 15; dac_max = 0; cyc = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(int'(dac_out), 8, "R1 dac");
    check(int'(symbol), 0, "R1 symbol");
    check(int'(bit_req), 0, "R1 bit_req");
    rst_n = 1'b1;

    // R2/R3: data mode, 15000 baud pulses -> 15000/833 ticks
    run_phase(60000, 0, 0, 0, "data");
    check(req_seen, 15000 / (BAUD_RL + 1), "R2 tick count");
    req_a = req_seen;

    run_phase(20000, 0, 1, 0, "R10 gated tone enable");
    // R10: tone enable off holds the output even across baud ticks
    dac_hold = m_dac;
    run_phase(4000, 0, 2, 0, "R10 enable off");
    @(negedge clk);
    check(int'(dac_out), dac_hold, "R10 hold");

    req_a = req_seen;
    run_phase(30000, 3, 0, 0, "R4 R6 alternating");
    check(req_seen - req_a, 0, "R4 no request");

    req_a = req_seen;
    run_phase(6000, 1, 0, 0, "R9 steady mark");
    run_phase(6000, 2, 0, 0, "R9 steady space");
    check(req_seen - req_a, 0, "R9 no request");

    run_phase(8000, 0, 0, 1, "R3 ones");
    // R8: table spans 1..15
    check(dac_min, 1, "R8 min level");
    check(dac_max, 15, "R8 max level");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule